// File: doc/BRIEF.md
# Prioritized Interrupt Bank

This block collects up to 32 interrupt request lines and turns them into two requests toward a processor: a normal request and a fast request. Each line has its own configuration word. The word chooses the output the line drives, whether the line is captured on a rising edge or sensed as a level, and a 5-bit priority. A per-line mask, a global gate and an acknowledge command control which requests are delivered. One winner is presented per output, and its line number can be read back.

Software uses a plain 32-bit register port. Writes take effect at the clock edge and reads are combinational. Several banks can be chained: the normal output of a lower bank drives one request line of a higher bank. A parameter disables fast routing, so a chained bank can only raise normal requests. A chained interrupt is retired by acknowledging the lower bank first and the higher bank second.

Top module: `prio_irq_bank`

## Requirements
- R1: After reset every line is masked, the global gate register reads 1, the status register and every configuration word read 0, and both outputs are low.
- R2: The configuration word of line n sits at word address n (byte offset 4·n). Bit 0 routes the line to the fast output, bit 1 selects the trigger (0 rising edge, 1 level) and bits 6:2 hold the priority. It reads back with bits 31:7 as 0.
- R3: With FIQ_CAPABLE = 0, bit 0 of every configuration word is stored and read as 0, and the fast output never rises. The normal output of such a bank can drive a line of another bank and is delivered there.
- R4: An edge-triggered line latches a rising input into its status bit, which stays 1 after the input falls, until it is acknowledged or cleared. Its output rises on the second clock edge after the input rises.
- R5: The status bit of a level-triggered line follows its input, with a delay of one clock edge.
- R6: The mask register sits at word 32, where bit n = 1 blocks line n. A masked edge request stays latched and is delivered after the line is unmasked.
- R7: Among pending, unmasked lines routed to the same output, the lowest priority value wins, and a tie goes to the lowest line number. The winner's line number reads at word 36 (normal) and word 37 (fast).
- R8: Writing the control register at word 34 with bit 0 = 1 acknowledges the presented normal request, and bit 1 = 1 acknowledges the presented fast request. The acknowledged edge latch is cleared, the output is low for the following cycle, and on the cycle after that the next winner is presented. An acknowledge of one output leaves the other untouched.
- R9: Any write to the status register at word 33 discards every latched edge request.
- R10: The global gate register at word 35 (bit 0, reset value 1) holds both outputs low while it is 1. Writing 0 enables delivery, and latched requests survive while the gate is closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| irqIn | input | NUM_LINES | Interrupt request lines |
| regAddr | input | ADDR_W | Register word address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | DATA_W | Register write data |
| regRdData | output | DATA_W | Register read data, combinational from regAddr |
| irqOut | output | 1 | Normal interrupt request |
| fiqOut | output | 1 | Fast interrupt request |

## Verification
The bench covers the following corner cases, each with the failure it would expose.

- **Priority tie.** Two lines of equal priority are made pending together; a design that compared with less-or-equal would hand the request to the higher line number.
- **Acknowledge gap.** The output is sampled in the cycle right after an acknowledge and again one cycle later. This catches a design with no low cycle, a design that clears the wrong latch, and a design whose normal acknowledge also drops the fast output.
- **Request held while blocked.** An edge arrives while its line is masked, and another is latched while the global gate is closed. A design that drops these requests never raises the output afterward.
- **Fast routing in a chained bank.** A lower bank with fast routing disabled is chained into a higher one. Writing bit 0 of a configuration word in the lower bank must read back 0 and never produce a fast request.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_LEVEL,
    RD_MASK,
    RD_STATUS,
    RD_GMASK,
    RD_SRC_IRQ,
    RD_SRC_FIQ
  } rdSel_e;

  typedef struct packed {
    logic   lvlWr;
    logic   maskWr;
    logic   statClr;
    logic   gmaskWr;
    logic   ackIrq;
    logic   ackFiq;
    rdSel_e rdSel;
  } strobes_t;

endpackage

// File: rtl/prio_irq_decode.sv
module prio_irq_decode
  import prio_irq_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int ADDR_W    = 6,
  localparam int LINE_W   = $clog2(NUM_LINES)
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [1:0]        ctrlBits,
  output strobes_t          stb,
  output logic [LINE_W-1:0] lineIdx
);

  localparam logic [ADDR_W-1:0] A_MASK    = ADDR_W'(NUM_LINES);
  localparam logic [ADDR_W-1:0] A_STATUS  = ADDR_W'(NUM_LINES + 1);
  localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(NUM_LINES + 2);
  localparam logic [ADDR_W-1:0] A_GMASK   = ADDR_W'(NUM_LINES + 3);
  localparam logic [ADDR_W-1:0] A_SRC_IRQ = ADDR_W'(NUM_LINES + 4);
  localparam logic [ADDR_W-1:0] A_SRC_FIQ = ADDR_W'(NUM_LINES + 5);

  assign lineIdx = regAddr[LINE_W-1:0];

  always_comb begin
    stb = '0;
    stb.rdSel = RD_NONE;
    if (regAddr < A_MASK) begin
      stb.rdSel = RD_LEVEL;
      stb.lvlWr = regWrEn;
    end else begin
      case (regAddr)
        A_MASK: begin
          stb.rdSel  = RD_MASK;
          stb.maskWr = regWrEn;
        end
        A_STATUS: begin
          stb.rdSel   = RD_STATUS;
          stb.statClr = regWrEn;
        end
        A_CTRL: begin
          stb.ackIrq = regWrEn & ctrlBits[0];
          stb.ackFiq = regWrEn & ctrlBits[1];
        end
        A_GMASK: begin
          stb.rdSel   = RD_GMASK;
          stb.gmaskWr = regWrEn;
        end
        A_SRC_IRQ: stb.rdSel = RD_SRC_IRQ;
        A_SRC_FIQ: stb.rdSel = RD_SRC_FIQ;
        default:   stb.rdSel = RD_NONE;
      endcase
    end
  end

endmodule

// File: rtl/prio_irq_arb.sv
module prio_irq_arb #(
  parameter int NUM_LINES = 32,
  parameter int PRIO_W    = 5,
  localparam int LINE_W   = $clog2(NUM_LINES)
) (
  input  logic [NUM_LINES-1:0]             cand,
  input  logic [NUM_LINES-1:0][PRIO_W-1:0] prio,
  output logic                             valid,
  output logic [LINE_W-1:0]                idx
);

  logic [PRIO_W-1:0] bestPrio;

  // Strict less-than keeps the lowest line number on a tie.
  always_comb begin
    valid    = 1'b0;
    idx      = '0;
    bestPrio = '1;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (cand[i] && (!valid || (prio[i] < bestPrio))) begin
        valid    = 1'b1;
        idx      = LINE_W'(i);
        bestPrio = prio[i];
      end
    end
  end

endmodule

// File: rtl/prio_irq_core.sv
module prio_irq_core
  import prio_irq_pkg::*;
#(
  parameter int NUM_LINES   = 32,
  parameter int PRIO_W      = 5,
  parameter int DATA_W      = 32,
  parameter int FIQ_CAPABLE = 1,
  localparam int LINE_W     = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqIn,
  input  strobes_t             stb,
  input  logic [LINE_W-1:0]    lineIdx,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    rdData,
  output logic                 irqOut,
  output logic                 fiqOut,
  output logic [NUM_LINES-1:0] maskOut,
  output logic                 gmaskOut,
  output logic [LINE_W-1:0]    srcIrq,
  output logic [LINE_W-1:0]    srcFiq
);

  logic [NUM_LINES-1:0]             routeQ, trigQ, inQ, pendQ, maskQ;
  logic [NUM_LINES-1:0][PRIO_W-1:0] prioQ;
  logic                             gmaskQ;
  logic [NUM_LINES-1:0]             stat;
  logic [1:0][NUM_LINES-1:0]        cand;
  logic [1:0]                       winValid, outQ, ackHit;
  logic [1:0][LINE_W-1:0]           winIdx, srcQ;

  // Per-line configuration words
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      routeQ <= '0;
      trigQ  <= '0;
      prioQ  <= '0;
    end else if (stb.lvlWr) begin
      routeQ[lineIdx] <= (FIQ_CAPABLE != 0) ? wrData[0] : 1'b0;
      trigQ[lineIdx]  <= wrData[1];
      prioQ[lineIdx]  <= wrData[2 +: PRIO_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ  <= '1;
      gmaskQ <= 1'b1;
    end else begin
      if (stb.maskWr)  maskQ  <= wrData[NUM_LINES-1:0];
      if (stb.gmaskWr) gmaskQ <= wrData[0];
    end
  end

  assign ackHit = {stb.ackFiq, stb.ackIrq} & outQ;

  // Input sampling and edge latches
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inQ   <= '0;
      pendQ <= '0;
    end else begin
      inQ <= irqIn;
      for (int i = 0; i < NUM_LINES; i++) begin
        if (trigQ[i])
          pendQ[i] <= 1'b0;
        else if (irqIn[i] && !inQ[i])
          pendQ[i] <= 1'b1;
        else if (stb.statClr)
          pendQ[i] <= 1'b0;
        else if ((ackHit[0] && srcQ[0] == LINE_W'(i)) ||
                 (ackHit[1] && srcQ[1] == LINE_W'(i)))
          pendQ[i] <= 1'b0;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_LINES; i++)
      stat[i] = trigQ[i] ? inQ[i] : pendQ[i];
  end

  assign cand[0] = stat & ~maskQ & ~routeQ;
  assign cand[1] = stat & ~maskQ & routeQ;

  for (genvar o = 0; o < 2; o++) begin : g_arb
    prio_irq_arb #(
      .NUM_LINES(NUM_LINES),
      .PRIO_W   (PRIO_W)
    ) u_arb (
      .cand (cand[o]),
      .prio (prioQ),
      .valid(winValid[o]),
      .idx  (winIdx[o])
    );
  end

  // Registered outputs; an acknowledge forces one low cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outQ <= '0;
      srcQ <= '0;
    end else begin
      for (int o = 0; o < 2; o++) begin
        if (ackHit[o]) begin
          outQ[o] <= 1'b0;
        end else begin
          outQ[o] <= winValid[o] & ~gmaskQ;
          if (winValid[o]) srcQ[o] <= winIdx[o];
        end
      end
    end
  end

  always_comb begin
    rdData = '0;
    case (stb.rdSel)
      RD_LEVEL:   rdData[PRIO_W+1:0] = {prioQ[lineIdx], trigQ[lineIdx], routeQ[lineIdx]};
      RD_MASK:    rdData[NUM_LINES-1:0] = maskQ;
      RD_STATUS:  rdData[NUM_LINES-1:0] = stat;
      RD_GMASK:   rdData[0] = gmaskQ;
      RD_SRC_IRQ: rdData[LINE_W-1:0] = srcQ[0];
      RD_SRC_FIQ: rdData[LINE_W-1:0] = srcQ[1];
      default:    rdData = '0;
    endcase
  end

  assign irqOut   = outQ[0];
  assign fiqOut   = outQ[1];
  assign maskOut  = maskQ;
  assign gmaskOut = gmaskQ;
  assign srcIrq   = srcQ[0];
  assign srcFiq   = srcQ[1];

endmodule

// File: rtl/prio_irq_bank.sv
module prio_irq_bank
  import prio_irq_pkg::*;
#(
  parameter int NUM_LINES   = 32,
  parameter int PRIO_W      = 5,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 6,
  parameter int FIQ_CAPABLE = 1,
  localparam int LINE_W     = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqIn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regWrEn,
  input  logic [DATA_W-1:0]    regWrData,
  output logic [DATA_W-1:0]    regRdData,
  output logic                 irqOut,
  output logic                 fiqOut
);

  strobes_t             stb;
  logic [LINE_W-1:0]    lineIdx;
  logic [NUM_LINES-1:0] maskQ;
  logic                 gmaskQ;
  logic [LINE_W-1:0]    srcIrq, srcFiq;

  prio_irq_decode #(
    .NUM_LINES(NUM_LINES),
    .ADDR_W   (ADDR_W)
  ) u_decode (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .ctrlBits(regWrData[1:0]),
    .stb     (stb),
    .lineIdx (lineIdx)
  );

  prio_irq_core #(
    .NUM_LINES  (NUM_LINES),
    .PRIO_W     (PRIO_W),
    .DATA_W     (DATA_W),
    .FIQ_CAPABLE(FIQ_CAPABLE)
  ) u_core (
    .clk     (clk),
    .rstN    (rstN),
    .irqIn   (irqIn),
    .stb     (stb),
    .lineIdx (lineIdx),
    .wrData  (regWrData),
    .rdData  (regRdData),
    .irqOut  (irqOut),
    .fiqOut  (fiqOut),
    .maskOut (maskQ),
    .gmaskOut(gmaskQ),
    .srcIrq  (srcIrq),
    .srcFiq  (srcFiq)
  );

endmodule

// File: rtl/prio_irq_bank_chk.sv
module prio_irq_bank_chk #(
  parameter int NUM_LINES   = 32,
  parameter int FIQ_CAPABLE = 1,
  localparam int LINE_W     = $clog2(NUM_LINES)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 ackIrq,
  input logic                 ackFiq,
  input logic                 irqOut,
  input logic                 fiqOut,
  input logic                 gmask,
  input logic [NUM_LINES-1:0] mask,
  input logic [LINE_W-1:0]    srcIrq,
  input logic [LINE_W-1:0]    srcFiq
);

  logic [NUM_LINES-1:0] pastMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastMask <= '1;
    else       pastMask <= mask;
  end

  p_gate_closed_r10: assert property (@(posedge clk) disable iff (!rstN)
    gmask |=> (!irqOut && !fiqOut));

  p_ack_gap_irq_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ackIrq && irqOut) |=> !irqOut);

  p_ack_gap_fiq_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ackFiq && fiqOut) |=> !fiqOut);

  p_no_fast_r3: assert property (@(posedge clk) disable iff (!rstN)
    (FIQ_CAPABLE == 0) |-> !fiqOut);

  p_unmasked_irq_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> !pastMask[srcIrq]);

  p_unmasked_fiq_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fiqOut) |-> !pastMask[srcFiq]);

endmodule

bind prio_irq_bank prio_irq_bank_chk #(
  .NUM_LINES  (NUM_LINES),
  .FIQ_CAPABLE(FIQ_CAPABLE)
) u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .ackIrq(stb.ackIrq),
  .ackFiq(stb.ackFiq),
  .irqOut(irqOut),
  .fiqOut(fiqOut),
  .gmask (gmaskQ),
  .mask  (maskQ),
  .srcIrq(srcIrq),
  .srcFiq(srcFiq)
);

// File: tb/test_prio_irq_bank.sv
`timescale 1ns/1ps
module test_prio_irq_bank;

  localparam logic [5:0] W_MASK = 6'd32, W_STAT = 6'd33, W_CTRL = 6'd34,
                         W_GATE = 6'd35, W_SRCI = 6'd36, W_SRCF = 6'd37;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] irqA = '0, irqB = '0, mainIn;
  logic [5:0]  aAddr = '0, bAddr = '0;
  logic        aWr = 1'b0, bWr = 1'b0;
  logic [31:0] aData = '0, bData = '0, aRd, bRd;
  logic        aIrq, aFiq, bIrq, bFiq;
  int          total = 0, bad = 0;

  always #2.5 clk = ~clk;

  // Lower bank's normal output feeds line 7 of the upper bank
  assign mainIn = {irqA[31:8], bIrq, irqA[6:0]};

  prio_irq_bank i_prio_irq_bank (
    .clk(clk), .rstN(rstN), .irqIn(mainIn), .regAddr(aAddr), .regWrEn(aWr),
    .regWrData(aData), .regRdData(aRd), .irqOut(aIrq), .fiqOut(aFiq));

  prio_irq_bank #(.FIQ_CAPABLE(0)) i_prio_irq_bank_low (
    .clk(clk), .rstN(rstN), .irqIn(irqB), .regAddr(bAddr), .regWrEn(bWr),
    .regWrData(bData), .regRdData(bRd), .irqOut(bIrq), .fiqOut(bFiq));

  // {bank, line, written word, expected read-back}
  localparam logic [69:0] VEC [8] = '{
    {1'b0, 5'd0,  32'h0000_007F, 32'h0000_007F},
    {1'b0, 5'd31, 32'hFFFF_FFFF, 32'h0000_007F},
    {1'b0, 5'd5,  32'h0000_000A, 32'h0000_000A},
    {1'b0, 5'd17, 32'h0000_0041, 32'h0000_0041},
    {1'b1, 5'd0,  32'h0000_007F, 32'h0000_007E},
    {1'b1, 5'd9,  32'h0000_0001, 32'h0000_0000},
    {1'b1, 5'd30, 32'h0000_0056, 32'h0000_0056},
    {1'b0, 5'd5,  32'h0000_0080, 32'h0000_0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int bank, input logic [5:0] addr, input logic [31:0] d);
    @(negedge clk);
    if (bank == 0) begin aAddr = addr; aData = d; aWr = 1'b1; end
    else           begin bAddr = addr; bData = d; bWr = 1'b1; end
    @(negedge clk);
    aWr = 1'b0;
    bWr = 1'b0;
  endtask

  task automatic rd(input int bank, input logic [5:0] addr, output logic [31:0] d);
    if (bank == 0) aAddr = addr; else bAddr = addr;
    #1;
    d = (bank == 0) ? aRd : bRd;
  endtask

  task automatic pulseA(input int line);
    irqA[line] = 1'b1;
    @(negedge clk);
    irqA[line] = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    step(2);
    rstN = 1'b1;
    step(1);
  endtask

  initial begin : watchdog
    #(200000 * 5);
    total++;
    bad++;
    $display("FAIL watchdog expired, all requirements");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    doReset();

    // R1 reset state
    rd(0, W_MASK, v); chk("R1 mask", v, 32'hFFFF_FFFF);
    rd(0, W_GATE, v); chk("R1 gate", v, 32'h1);
    rd(0, W_STAT, v); chk("R1 status", v, 32'h0);
    rd(0, 6'd5, v);   chk("R1 config", v, 32'h0);
    chk("R1 outputs", {30'd0, aIrq, aFiq}, 32'h0);

    // R2 / R3 configuration word table
    for (int k = 0; k < 8; k++) begin
      wr(int'(VEC[k][69]), {1'b0, VEC[k][68:64]}, VEC[k][63:32]);
      rd(int'(VEC[k][69]), {1'b0, VEC[k][68:64]}, v);
      chk(VEC[k][69] ? "R3 forced route" : "R2 config word", v, VEC[k][31:0]);
    end

    doReset();
    wr(0, W_GATE, 32'h0);
    wr(0, 6'd3,  32'h10);   // prio 4, edge
    wr(0, 6'd9,  32'h08);   // prio 2, edge
    wr(0, 6'd12, 32'h0A);   // prio 2, level
    wr(0, 6'd20, 32'h09);   // prio 2, edge, fast
    wr(0, 6'd7,  32'h02);   // prio 0, level (chained input)
    wr(0, W_MASK, ~32'h0010_1288);

    // R4 edge capture and latency
    pulseA(3);
    step(1);
    chk("R4 irq after edge", {31'd0, aIrq}, 32'h1);
    rd(0, W_SRCI, v); chk("R4 source", v, 32'd3);
    step(3);
    rd(0, W_STAT, v); chk("R4 latch held", v & 32'h8, 32'h8);

    // R7 priority and tie
    pulseA(9);
    step(1);
    rd(0, W_SRCI, v); chk("R7 lower value wins", v, 32'd9);
    irqA[12] = 1'b1;
    step(2);
    rd(0, W_STAT, v); chk("R5 level high", v & 32'h1000, 32'h1000);
    rd(0, W_SRCI, v); chk("R7 tie lowest line", v, 32'd9);

    // R8 acknowledge gap
    wr(0, W_CTRL, 32'h1);
    chk("R8 gap cycle", {31'd0, aIrq}, 32'h0);
    step(1);
    chk("R8 next presented", {31'd0, aIrq}, 32'h1);
    rd(0, W_SRCI, v); chk("R8 next winner", v, 32'd12);
    irqA[12] = 1'b0;
    step(1);
    rd(0, W_STAT, v); chk("R5 level follows", v & 32'h1000, 32'h0);
    step(1);
    rd(0, W_SRCI, v); chk("R7 remaining line", v, 32'd3);
    wr(0, W_CTRL, 32'h1);
    step(2);
    chk("R8 all retired", {31'd0, aIrq}, 32'h0);

    // R6 masked edge retained
    wr(0, W_MASK, ~32'h0010_1280);
    pulseA(3);
    step(2);
    chk("R6 masked quiet", {31'd0, aIrq}, 32'h0);
    rd(0, W_STAT, v); chk("R6 latched while masked", v & 32'h8, 32'h8);
    wr(0, W_MASK, ~32'h0010_1288);
    step(1);
    chk("R6 delivered on unmask", {31'd0, aIrq}, 32'h1);

    // R9 status clear
    wr(0, W_STAT, 32'h0);
    step(1);
    chk("R9 output dropped", {31'd0, aIrq}, 32'h0);
    rd(0, W_STAT, v); chk("R9 status cleared", v, 32'h0);

    // R2 fast routing, R8 independence
    pulseA(20);
    step(1);
    chk("R2 fast output", {30'd0, aFiq, aIrq}, 32'h2);
    rd(0, W_SRCF, v); chk("R7 fast source", v, 32'd20);
    wr(0, W_CTRL, 32'h1);
    step(1);
    chk("R8 normal ack leaves fast", {31'd0, aFiq}, 32'h1);
    wr(0, W_CTRL, 32'h2);
    chk("R8 fast ack", {31'd0, aFiq}, 32'h0);
    step(2);
    chk("R8 fast retired", {31'd0, aFiq}, 32'h0);

    // R10 global gate
    pulseA(9);
    step(1);
    chk("R10 open gate", {31'd0, aIrq}, 32'h1);
    wr(0, W_GATE, 32'h1);
    step(1);
    chk("R10 closed gate", {31'd0, aIrq}, 32'h0);
    rd(0, W_STAT, v); chk("R10 request kept", v & 32'h200, 32'h200);
    wr(0, W_GATE, 32'h0);
    step(1);
    chk("R10 reopened", {31'd0, aIrq}, 32'h1);
    wr(0, W_CTRL, 32'h1);
    step(2);

    // R3 chained bank
    wr(1, W_GATE, 32'h0);
    wr(1, 6'd4, 32'h01);
    wr(1, W_MASK, ~32'h10);
    irqB[4] = 1'b1;
    @(negedge clk);
    irqB[4] = 1'b0;
    step(3);
    chk("R3 chained delivery", {31'd0, aIrq}, 32'h1);
    rd(0, W_SRCI, v); chk("R3 chained line", v, 32'd7);
    rd(1, W_SRCI, v); chk("R3 lower source", v, 32'd4);
    chk("R3 lower no fast", {31'd0, bFiq}, 32'h0);
    wr(1, W_CTRL, 32'h1);
    wr(0, W_CTRL, 32'h1);
    step(2);
    chk("R3 chained retired", {30'd0, aIrq, bIrq}, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule